// File: doc/BRIEF.md
# Microwire serial master controller

This block is the master end of a half-duplex three-wire serial link. For each frame it takes one 8-bit control word from the host, shifts it out on the data-out line, leaves one serial clock cycle for the slave to turn the line around, and then clocks in a reply whose length is programmed between 4 and 16 bits. It drives the serial clock, which idles low and is divided down from the system clock, and an active-low frame select that stays low for the whole frame.

Control words enter through a valid/ready handshake. Each finished reply is presented right-justified on a holding register with a one-cycle valid pulse. The host marks the word as consumed with a read strobe. If a new word lands while the old one is still unread, the block flags an overrun. In continuous mode the block chains frames with no gap and never releases frame select, as long as the host has the next control word ready when the current reply ends. Without a waiting word, the block releases frame select and goes idle.

The data-out driver is modelled as a value plus an output enable. The enable is high only while control bits are being sent.

Top module: `mw_master`

## Requirements
- R1: After reset, fss_n is 1, sclk is 0, sdo_oe is 0, rx_valid and rx_overrun are 0, and cmd_ready is 1.
- R2: A control word is accepted in a cycle with cmd_valid and cmd_ready both high. Its 8 bits appear on sdo most significant bit first. The first bit is present from acceptance, each later bit changes together with a falling edge of sclk, and sdo never changes while sclk is high.
- R3: fss_n goes low when a word is accepted and stays low until the falling sclk edge that follows the last reply bit. In single mode (cfg_cont=0) fss_n then returns high and sclk stays low while fss_n is high.
- R4: Each high or low phase of sclk lasts cfg_div+1 system clock cycles.
- R5: After the 8th control bit there is exactly one sclk cycle in which nothing is sampled. sdo_oe is already 0 at its rising edge.
- R6: The reply is sampled on rising sclk edges, most significant bit first, for L bits. L is cfg_rx_len clamped to the range 4..16, and it is latched when the word is accepted. rx_data holds the reply right-justified, with the unused upper bits 0.
- R7: sdo_oe is 1 only during the command phase, that is, at every rising sclk edge that carries a control bit and at no other rising edge.
- R8: Each reply is moved to rx_data on the falling sclk edge after its last bit. rx_valid pulses for one cycle, and rx_data holds its value until the next reply arrives.
- R9: With cfg_cont=1 and cmd_valid high when a reply ends, the next word's first bit drives sdo at that same falling edge and fss_n stays low. In the RX phase, cmd_ready is high only in that cycle.
- R10: With cfg_cont=1 and no word waiting when a reply ends, fss_n returns high and the block returns to idle with cmd_ready high.
- R11: rx_overrun pulses together with rx_valid when the previous reply was not consumed by rx_read. rx_read in the cycle of an rx_valid pulse, or any time after it, consumes that reply.
- R12: sdi is ignored at every sclk edge outside the reply window, including the turnaround cycle and the edges after the last reply bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Half-period of sclk minus one, in system cycles |
| cfg_rx_len | input | LEN_W | Reply length in bits, clamped to 4..MAX_RX |
| cfg_cont | input | 1 | 1 = chain frames while words are waiting |
| cmd_data | input | CMD_W | Control word to send |
| cmd_valid | input | 1 | Control word offered |
| cmd_ready | output | 1 | Control word can be taken this cycle |
| rx_data | output | MAX_RX | Last reply, right-justified |
| rx_valid | output | 1 | One-cycle pulse: new reply in rx_data |
| rx_overrun | output | 1 | One-cycle pulse: reply arrived before the previous one was read |
| rx_read | input | 1 | Host consumes the held reply |
| sclk | output | 1 | Serial clock, idles low |
| fss_n | output | 1 | Frame select, active low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach is the chained frame. The next control word has to be offered before the current reply ends, so that it is taken in the single cycle when the last falling edge arrives. To get there, the driver queues several words back to back and holds each one valid until it is taken. The bench then counts fss_n releases across the whole burst. The slave model drives random bits on sdi outside the reply window, so a sample taken at the wrong edge corrupts a scoreboard compare.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_TURN,
    ST_RX
  } mw_state_t;

  localparam int MIN_RX_LEN = 4;

  function automatic int clamp_len(input int req, input int max_len);
    if (req < MIN_RX_LEN) return MIN_RX_LEN;
    if (req > max_len) return max_len;
    return req;
  endfunction

endpackage

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             tick_rise,
  output logic             tick_fall
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick      = run && (cnt == div);
  assign tick_rise = tick && !sclk;
  assign tick_fall = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mw_txshift.sv
module mw_txshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         bit_out
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end

  assign bit_out = q[W-1];

endmodule

// File: rtl/mw_rxshift.sv
module mw_rxshift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CMD_W  = 8,
  parameter int MAX_RX = 16,
  parameter int LEN_W  = $clog2(MAX_RX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_rx_len,
  input  logic              cfg_cont,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic [MAX_RX-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_overrun,
  input  logic              rx_read,
  output logic              sclk,
  output logic              fss_n,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);

  localparam int CNT_MAX = (CMD_W > MAX_RX) ? CMD_W : MAX_RX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  mw_state_t        state;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] len_q;
  logic             run;
  logic             tick_rise, tick_fall;
  logic             last_rx, reply_done, accept, xfer, tx_shift;
  logic             pending;
  logic [MAX_RX-1:0] rx_q;
  logic [CNT_W-1:0] len_req;

  mw_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .div(cfg_div),
    .sclk(sclk), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  assign len_req    = CNT_W'(clamp_len(int'(cfg_rx_len), MAX_RX));
  assign last_rx    = (state == ST_RX) && (bit_cnt == len_q);
  assign reply_done = last_rx && tick_fall;
  assign cmd_ready  = (state == ST_IDLE) || (reply_done && cfg_cont);
  assign accept     = cmd_valid && cmd_ready;
  assign xfer       = reply_done;
  assign tx_shift   = (state == ST_CMD) && tick_fall;

  mw_txshift #(.W(CMD_W)) u_tx (
    .clk(clk), .rst(rst), .load(accept), .din(cmd_data),
    .shift(tx_shift), .bit_out(sdo)
  );

  mw_rxshift #(.W(MAX_RX)) u_rx (
    .clk(clk), .rst(rst), .clr(accept),
    .en((state == ST_RX) && tick_rise && !last_rx),
    .din(sdi), .q(rx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      len_q   <= CNT_W'(MIN_RX_LEN);
      run     <= 1'b0;
      fss_n   <= 1'b1;
      sdo_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
            len_q   <= len_req;
            run     <= 1'b1;
            fss_n   <= 1'b0;
            sdo_oe  <= 1'b1;
          end
        end
        ST_CMD: begin
          if (tick_fall) begin
            if (bit_cnt == CNT_W'(CMD_W - 1)) begin
              state   <= ST_TURN;
              bit_cnt <= '0;
              sdo_oe  <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_TURN: begin
          if (tick_fall) state <= ST_RX;
        end
        ST_RX: begin
          if (tick_rise && !last_rx) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (reply_done) begin
            bit_cnt <= '0;
            if (accept) begin
              state  <= ST_CMD;
              len_q  <= len_req;
              sdo_oe <= 1'b1;
            end else begin
              state <= ST_IDLE;
              run   <= 1'b0;
              fss_n <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // receive holding register and host-side flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
      pending    <= 1'b0;
    end else begin
      rx_valid   <= xfer;
      rx_overrun <= xfer && pending && !rx_read;
      if (xfer) rx_data <= rx_q;
      if (rx_valid)     pending <= !rx_read;
      else if (rx_read) pending <= 1'b0;
    end
  end

  // R3
  fss_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !fss_n);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fss_n |-> !sclk);

  // R7
  oe_cmd_only_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (state == ST_CMD));

  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R11
  ovr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> rx_valid);

  // R9
  ready_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && state != ST_IDLE) |-> (state == ST_RX && sclk && cfg_cont));

endmodule

// File: tb/mw_master_tb.sv
`timescale 1ns/1ps
module mw_master_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd1;
  logic [4:0]  cfg_rx_len = 5'd8;
  logic        cfg_cont = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] rx_data;
  logic        rx_valid, rx_overrun, rx_read;
  logic        sclk, fss_n, sdo, sdo_oe;
  logic        sdi = 1'b0;

  logic auto_read = 1'b1;
  logic man_rd = 1'b0;
  assign rx_read = auto_read ? rx_valid : man_rd;

  always #5 clk = ~clk;

  mw_master u_dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_rx_len(cfg_rx_len),
    .cfg_cont(cfg_cont), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_overrun(rx_overrun), .rx_read(rx_read), .sclk(sclk), .fss_n(fss_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  int checks = 0;
  int fails  = 0;
  int eff_len = 8;
  logic [7:0]  exp_cmd_q[$];
  logic [16:0] exp_rx_q[$];
  logic [15:0] last_rx = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reply_of(input logic [7:0] c, input int n);
    logic [15:0] r;
    r = {c, c ^ 8'h5A} ^ 16'h3C96;
    return r & 16'((32'd1 << n) - 1);
  endfunction

  function automatic int clamp(input int v);
    if (v < 4) return 4;
    if (v > 16) return 16;
    return v;
  endfunction

  task automatic set_cfg(input int div, input int len, input bit cont);
    cfg_div = 8'(div);
    cfg_rx_len = 5'(len);
    cfg_cont = cont;
    eff_len = clamp(len);
  endtask

  // driver: push expectations, then hand the word over
  task automatic send(input logic [7:0] c, input bit ovr);
    exp_cmd_q.push_back(c);
    exp_rx_q.push_back({ovr, reply_of(c, eff_len)});
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_rx_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // slave model
  int k = 0;
  logic [7:0]  cap = '0;
  logic [15:0] rep = '0;
  int fss_rises = 0;

  always @(posedge fss_n) begin
    k = 0;
    fss_rises++;
  end

  always @(posedge sclk) begin
    if (!fss_n) begin
      if (k < 8) begin
        chk(sdo_oe === 1'b1, "R7 oe in command phase", sdo_oe, 1);
        cap = {cap[6:0], sdo};
        if (k == 7) begin
          if (exp_cmd_q.size() == 0) chk(0, "R2 unexpected command", cap, 0);
          else begin
            logic [7:0] e;
            e = exp_cmd_q.pop_front();
            chk(cap == e, "R2 command bits", cap, e);
          end
          rep = reply_of(cap, eff_len);
        end
      end else begin
        chk(sdo_oe === 1'b0, "R5 oe released after command", sdo_oe, 0);
      end
      k++;
      if (k == 9 + eff_len) k = 0;
    end
  end

  always @(negedge sclk) begin
    if (!fss_n && k >= 9) sdi = rep[eff_len - 1 - (k - 9)];
    else sdi = 1'($urandom_range(0, 1)); // R12 junk outside the window
  end

  // R4 half-period monitor
  time t_r = 0;
  bit  have_r = 1'b0;
  always @(posedge sclk) begin
    t_r = $time;
    have_r = 1'b1;
  end
  always @(negedge sclk) begin
    if (have_r) chk(($time - t_r) == time'((cfg_div + 1) * 10), "R4 sclk high phase",
                    int'(($time - t_r) / 10), cfg_div + 1);
    have_r = 1'b0;
  end

  // monitor: compare replies against the scoreboard
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (exp_rx_q.size() == 0) chk(0, "R8 unexpected rx_valid", rx_data, 0);
      else begin
        logic [16:0] e;
        e = exp_rx_q.pop_front();
        chk(rx_data == e[15:0], "R6 reply data", rx_data, e[15:0]);
        chk(rx_overrun == e[16], "R11 overrun flag", rx_overrun, e[16]);
        last_rx = e[15:0];
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int r0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(fss_n == 1, "R1 fss_n", fss_n, 1);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(sdo_oe == 0, "R1 sdo_oe", sdo_oe, 0);
    chk(rx_valid == 0 && rx_overrun == 0, "R1 rx flags", rx_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);

    // single frames, R2 R3 R6 R8
    set_cfg(1, 8, 0);
    r0 = fss_rises;
    send(8'hA5, 0);
    send(8'h3C, 0);
    wait_done();
    chk(fss_rises - r0 == 2, "R3 frame select per single frame", fss_rises - r0, 2);
    chk(sclk == 0 && fss_n == 1, "R3 idle lines", {sclk, fss_n}, 1);
    chk(rx_data == last_rx, "R8 rx_data held", rx_data, last_rx);

    set_cfg(0, 4, 0);
    send(8'hF0, 0);
    set_cfg(2, 16, 0);
    wait_done();
    send(8'h81, 0);
    wait_done();

    // R6 clamping
    set_cfg(1, 2, 0);
    send(8'h6E, 0);
    wait_done();
    set_cfg(1, 20, 0);
    send(8'hC7, 0);
    wait_done();

    // R9 R10 continuous burst
    set_cfg(1, 12, 1);
    r0 = fss_rises;
    fork
      begin send(8'h11, 0); send(8'h22, 0); send(8'h33, 0); end
    join
    wait_done();
    chk(fss_rises - r0 == 1, "R9 fss_n held across burst", fss_rises - r0, 1);
    chk(fss_n == 1 && cmd_ready == 1, "R10 idle after burst", {fss_n, cmd_ready}, 3);

    set_cfg(0, 4, 1);
    r0 = fss_rises;
    send(8'hE1, 0);
    send(8'h7B, 0);
    wait_done();
    chk(fss_rises - r0 == 1, "R9 minimum length burst", fss_rises - r0, 1);

    // R11 overrun
    set_cfg(1, 6, 0);
    auto_read = 1'b0;
    send(8'h55, 0);
    wait_done();
    send(8'hAA, 1);
    wait_done();
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    auto_read = 1'b1;
    send(8'h99, 0);
    wait_done();

    chk(exp_cmd_q.size() == 0 && exp_rx_q.size() == 0, "R8 scoreboard drained",
        exp_rx_q.size(), 0);
    summary();
    $finish;
  end

endmodule